// File: doc/BRIEF.md
# Stack Call/Return Sequencer

This unit carries out the stack side of subroutine linkage and register saving for an 8-bit processor whose stack pointer is 16 bits wide and whose data memory is one byte wide. It takes one command at a time. For each command it runs the needed byte reads and writes in a fixed order, works out the new stack pointer and returns the new program counter or the register-pair value that was read.

The command set covers eight operations: save a pair, restore a pair, call, call on condition, return, return on condition, restart to one of eight fixed low vectors, and swap the top of the stack with a pair. Conditional commands test one of eight flag conditions. A command whose condition is false finishes at once and touches no memory. The caller gives the current stack pointer with each command, together with the fall-through program counter, which is also the return address that a call saves. The results are registered, and they are valid while `done` is high.

Memory is reached through a request/ready handshake. A request, with its address, direction and write data, is held until `mem_ready` is seen high at a rising clock edge. Read data is taken in at that same edge.

Top module: `stk_seq`

## Requirements
- R1: Op code 0 (save pair) writes the pair's high byte at SP-1 and then its low byte at SP-2. The result SP is SP-2 and the result PC is the fall-through value.
- R2: Op code 1 (restore pair) reads the low byte at SP and then the high byte at SP+1. It returns them as `res_pair`, with SP+2 as the result SP.
- R3: Op code 2 (call) writes the fall-through PC high byte at SP-1 and then its low byte at SP-2. The result PC is `cmd_target` and the result SP is SP-2.
- R4: Op code 4 (return) reads the PC low byte at SP and then its high byte at SP+1. It returns that value as both `res_pc` and `res_pair`, and SP+2 as the result SP.
- R5: Op codes 3 (conditional call) and 5 (conditional return) act as op codes 2 and 4 when the condition holds. The condition codes are: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear (odd), 5 parity set (even), 6 sign clear, 7 sign set.
- R6: Op code 6 (restart) acts as a call whose target is `cmd_vec` times 8, so the vectors run from 0x0000 to 0x0038.
- R7: Op code 7 (swap) runs four accesses in this order: read SP, write the pair's low byte at SP, read SP+1, write the pair's high byte at SP+1. It returns the old memory word as `res_pair`, and SP is unchanged.
- R8: A conditional command whose condition is false raises `done` in the cycle after acceptance. It makes no memory request and sets `res_taken` to 0. It returns the fall-through PC, the unchanged SP and a zero pair.
- R9: A memory request keeps its address, direction and write data until `mem_ready` is high at a rising edge. The access completes only at such an edge.
- R10: `busy` is high from the cycle after a command whose condition holds is accepted, until the edge where its last access completes. `done` pulses for one cycle at that edge, with `res_taken` set to 1. Commands offered while `busy` is high are ignored.
- R11: Every stack address and every result SP wraps modulo 65536.
- R12: After reset, `busy`, `done`, `mem_req`, `res_taken`, `res_pc`, `res_sp` and `res_pair` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered; taken when busy is low |
| cmd_op | input | 3 | Operation code (see R1 to R7) |
| cmd_cond | input | 3 | Condition code for op codes 3 and 5 |
| cmd_vec | input | 3 | Restart vector number |
| cmd_sp | input | 16 | Current stack pointer |
| cmd_pair | input | 16 | Pair value to save or swap |
| cmd_target | input | 16 | Call target address |
| cmd_next_pc | input | 16 | Fall-through PC, saved by calls |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag |
| flag_parity | input | 1 | Parity flag (1 = even) |
| flag_sign | input | 1 | Sign flag |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this edge |
| done | output | 1 | One-cycle completion pulse |
| res_taken | output | 1 | 1 if the command ran its accesses |
| res_pc | output | 16 | Resulting program counter |
| res_sp | output | 16 | Resulting stack pointer |
| res_pair | output | 16 | Word read from the stack, else zero |

## Verification
Random commands draw the op, the condition, the flags, the stack pointer and the data independently. Each condition is therefore tried with its flag both set and clear, which separates a taken path from a skipped one and separates each polarity from its partner. Directed cases put SP at 0x0000 and 0xFFFF, so that the address wrap can be told apart from a plain add. They also hold `mem_ready` low for several cycles, to show that the request does not move while it waits. Commands offered during busy cycles test that nothing queued or started behind the running one. The byte order is checked access by access against an independent model, which tells apart a low/high swap or a misplaced offset that a final result alone would hide.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_CALLC = 3'd3,
    OP_RET   = 3'd4,
    OP_RETC  = 3'd5,
    OP_RST   = 3'd6,
    OP_XCHG  = 3'd7
  } op_e;

  // One byte access: direction, offset from SP (2-bit signed), byte half.
  typedef struct packed {
    logic       wr;
    logic [1:0] off;
    logic       hi;
  } step_t;

  localparam logic [1:0] OFF_M2 = 2'b10;
  localparam logic [1:0] OFF_M1 = 2'b11;
  localparam logic [1:0] OFF_Z  = 2'b00;
  localparam logic [1:0] OFF_P1 = 2'b01;

  function automatic logic is_cond(op_e op);
    return (op == OP_CALLC) || (op == OP_RETC);
  endfunction

  function automatic logic pushes_pc(op_e op);
    return (op == OP_CALL) || (op == OP_CALLC) || (op == OP_RST);
  endfunction

  function automatic logic pops_pc(op_e op);
    return (op == OP_RET) || (op == OP_RETC);
  endfunction

  function automatic logic reads_pair(op_e op);
    return (op == OP_POP) || pops_pc(op) || (op == OP_XCHG);
  endfunction

  function automatic logic [1:0] last_step(op_e op);
    return (op == OP_XCHG) ? 2'd3 : 2'd1;
  endfunction

  // SP change at completion, 3-bit signed: -2, +2 or 0.
  function automatic logic [2:0] sp_delta(op_e op);
    case (op)
      OP_PUSH, OP_CALL, OP_CALLC, OP_RST: return 3'b110;
      OP_POP, OP_RET, OP_RETC:            return 3'b010;
      default:                            return 3'b000;
    endcase
  endfunction

  function automatic step_t step_of(op_e op, logic [1:0] idx);
    step_t s;
    case (op)
      OP_PUSH, OP_CALL, OP_CALLC, OP_RST:
        s = (idx == 2'd0) ? '{wr: 1'b1, off: OFF_M1, hi: 1'b1}
                          : '{wr: 1'b1, off: OFF_M2, hi: 1'b0};
      OP_XCHG:
        case (idx)
          2'd0:    s = '{wr: 1'b0, off: OFF_Z,  hi: 1'b0};
          2'd1:    s = '{wr: 1'b1, off: OFF_Z,  hi: 1'b0};
          2'd2:    s = '{wr: 1'b0, off: OFF_P1, hi: 1'b1};
          default: s = '{wr: 1'b1, off: OFF_P1, hi: 1'b1};
        endcase
      default:
        s = (idx == 2'd0) ? '{wr: 1'b0, off: OFF_Z,  hi: 1'b0}
                          : '{wr: 1'b0, off: OFF_P1, hi: 1'b1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/stk_cond.sv
module stk_cond (
  input  logic [2:0] cond,
  input  logic       f_zero,
  input  logic       f_carry,
  input  logic       f_parity,
  input  logic       f_sign,
  output logic       ok
);
  localparam int N_COND = 8;

  logic [3:0]        flag_v;
  logic [N_COND-1:0] truth;

  assign flag_v = {f_sign, f_parity, f_carry, f_zero};

  // Code pairs share a flag; the low code bit picks the polarity.
  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    localparam int   FSEL = g / 2;
    localparam logic POL  = logic'(g % 2);
    assign truth[g] = (flag_v[FSEL] == POL);
  end

  assign ok = truth[cond];
endmodule

// File: rtl/stk_agen.sv
module stk_agen import stk_pkg::*; #(
  parameter  int DW = BYTE_W,
  localparam int PW = 2 * DW
) (
  input  op_e          op,
  input  logic [1:0]   step,
  input  logic [PW-1:0] sp,
  input  logic [PW-1:0] wval,
  output logic [PW-1:0] addr,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic          cur_hi
);
  step_t s;

  assign s      = step_of(op, step);
  assign addr   = sp + {{(PW-2){s.off[1]}}, s.off};
  assign we     = s.wr;
  assign cur_hi = s.hi;
  assign wdata  = s.hi ? wval[PW-1:DW] : wval[DW-1:0];
endmodule

// File: rtl/stk_rdcap.sv
module stk_rdcap #(
  parameter  int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic          hi,
  input  logic [DW-1:0] rdata,
  output logic [PW-1:0] pair_now
);
  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (rd_fire) begin
      if (hi) hi_q <= rdata;
      else    lo_q <= rdata;
    end
  end

  // The high byte may arrive in the completing cycle itself.
  assign pair_now = {(rd_fire && hi) ? rdata : hi_q, lo_q};
endmodule

// File: rtl/stk_seq.sv
module stk_seq import stk_pkg::*; #(
  parameter  int DW = BYTE_W,
  localparam int PW = 2 * DW,
  localparam int VW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [2:0]    cmd_cond,
  input  logic [VW-1:0] cmd_vec,
  input  logic [PW-1:0] cmd_sp,
  input  logic [PW-1:0] cmd_pair,
  input  logic [PW-1:0] cmd_target,
  input  logic [PW-1:0] cmd_next_pc,
  input  logic          flag_zero,
  input  logic          flag_carry,
  input  logic          flag_parity,
  input  logic          flag_sign,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [PW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          done,
  output logic          res_taken,
  output logic [PW-1:0] res_pc,
  output logic [PW-1:0] res_sp,
  output logic [PW-1:0] res_pair
);
  op_e           cmd_op_e, op_q;
  logic          busy_q, done_q, taken_q;
  logic [1:0]    step_q;
  logic [PW-1:0] sp_q, wval_q, tgt_q, npc_q;
  logic [PW-1:0] res_pc_q, res_sp_q, res_pair_q;

  // Named events for the control path and the assertions.
  logic          cond_ok, accept_w, go_w, skip_w, xfer_w, final_w;
  logic          cur_hi;
  logic [PW-1:0] pair_now, sp_next_w, vec_addr_w, sp_dist_w;
  logic [2:0]    dsp;

  assign cmd_op_e = op_e'(cmd_op);

  stk_cond u_cond (
    .cond     (cmd_cond),
    .f_zero   (flag_zero),
    .f_carry  (flag_carry),
    .f_parity (flag_parity),
    .f_sign   (flag_sign),
    .ok       (cond_ok)
  );

  assign accept_w = cmd_valid && !busy_q;
  assign go_w     = accept_w && (!is_cond(cmd_op_e) || cond_ok);
  assign skip_w   = accept_w && !go_w;
  assign xfer_w   = busy_q && mem_ready;
  assign final_w  = xfer_w && (step_q == last_step(op_q));

  stk_agen #(.DW(DW)) u_agen (
    .op     (op_q),
    .step   (step_q),
    .sp     (sp_q),
    .wval   (wval_q),
    .addr   (mem_addr),
    .we     (mem_we),
    .wdata  (mem_wdata),
    .cur_hi (cur_hi)
  );

  stk_rdcap #(.DW(DW)) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (xfer_w && !mem_we),
    .hi       (cur_hi),
    .rdata    (mem_rdata),
    .pair_now (pair_now)
  );

  assign dsp        = sp_delta(op_q);
  assign sp_next_w  = sp_q + {{(PW-3){dsp[2]}}, dsp};
  assign vec_addr_w = PW'({cmd_vec, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      taken_q    <= 1'b0;
      step_q     <= '0;
      op_q       <= OP_PUSH;
      sp_q       <= '0;
      wval_q     <= '0;
      tgt_q      <= '0;
      npc_q      <= '0;
      res_pc_q   <= '0;
      res_sp_q   <= '0;
      res_pair_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (skip_w) begin
        done_q     <= 1'b1;
        taken_q    <= 1'b0;
        res_pc_q   <= cmd_next_pc;
        res_sp_q   <= cmd_sp;
        res_pair_q <= '0;
      end else if (go_w) begin
        busy_q <= 1'b1;
        step_q <= '0;
        op_q   <= cmd_op_e;
        sp_q   <= cmd_sp;
        wval_q <= pushes_pc(cmd_op_e) ? cmd_next_pc : cmd_pair;
        tgt_q  <= (cmd_op_e == OP_RST) ? vec_addr_w : cmd_target;
        npc_q  <= cmd_next_pc;
      end else if (xfer_w) begin
        if (final_w) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          taken_q    <= 1'b1;
          res_sp_q   <= sp_next_w;
          res_pair_q <= reads_pair(op_q) ? pair_now : '0;
          if (pushes_pc(op_q))    res_pc_q <= tgt_q;
          else if (pops_pc(op_q)) res_pc_q <= pair_now;
          else                    res_pc_q <= npc_q;
        end else begin
          step_q <= step_q + 2'd1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign mem_req   = busy_q;
  assign done      = done_q;
  assign res_taken = taken_q;
  assign res_pc    = res_pc_q;
  assign res_sp    = res_sp_q;
  assign res_pair  = res_pair_q;

  assign sp_dist_w = mem_addr - sp_q;

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid)); // R10
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_taken) |-> !mem_req); // R8
  AST_ADDR_NEAR_SP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (sp_dist_w >= {PW{1'b1}} - PW'(1) || sp_dist_w <= PW'(1))); // R11
  AST_SWAP_KEEPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_taken && op_q == OP_XCHG) |-> (res_sp == sp_q)); // R7
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_q <= last_step(op_q))); // R10
endmodule

// File: tb/tb_stk_seq.sv
`timescale 1ns/1ps
module tb_stk_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0, cmd_cond = '0, cmd_vec = '0;
  logic [15:0] cmd_sp = '0, cmd_pair = '0, cmd_target = '0, cmd_next_pc = '0;
  logic        flag_zero = 1'b0, flag_carry = 1'b0, flag_parity = 1'b0, flag_sign = 1'b0;
  logic        busy, mem_req, mem_we, done, res_taken;
  logic [15:0] mem_addr, res_pc, res_sp, res_pair;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        hold_rdy = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0]  mem  [0:255];
  logic [7:0]  pre  [0:255];
  logic [7:0]  post [0:255];
  logic [15:0] log_addr [0:7];
  logic        log_we   [0:7];
  logic [7:0]  log_data [0:7];
  int          log_n = 0;

  always #2.5 clk = ~clk;

  stk_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cond(cmd_cond), .cmd_vec(cmd_vec), .cmd_sp(cmd_sp), .cmd_pair(cmd_pair),
    .cmd_target(cmd_target), .cmd_next_pc(cmd_next_pc),
    .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_parity(flag_parity),
    .flag_sign(flag_sign), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done(done), .res_taken(res_taken), .res_pc(res_pc),
    .res_sp(res_sp), .res_pair(res_pair)
  );

  // Byte memory model, aliased on the low address byte.
  always @(negedge clk) begin
    mem_ready <= mem_req && !hold_rdy && ($urandom % 4 != 0);
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (log_n < 8) begin
        log_addr[log_n] = mem_addr;
        log_we[log_n]   = mem_we;
        log_data[log_n] = mem_wdata;
      end
      log_n = log_n + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic bit bench_cond(input logic [2:0] c, input logic [3:0] f);
    // f = {sign, parity, carry, zero}
    case (c)
      3'd0: return !f[0];
      3'd1: return  f[0];
      3'd2: return !f[1];
      3'd3: return  f[1];
      3'd4: return !f[2];
      3'd5: return  f[2];
      3'd6: return !f[3];
      default: return f[3];
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd4: return "R4";
      3'd6: return "R6";
      3'd7: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic run(input string tag, input logic [2:0] op, input logic [2:0] cnd,
                     input logic [2:0] vec, input logic [15:0] sp, input logic [15:0] pair,
                     input logic [15:0] tgt, input logic [15:0] npc, input logic [3:0] flg,
                     input bit noise, input int stall);
    bit          is_c, tk;
    int          en;
    int          w;
    logic [15:0] ea [0:3];
    bit          ew [0:3];
    logic [7:0]  ed [0:3];
    logic [15:0] epc, esp, epair, sv, s1;
    int          mism;
    for (int i = 0; i < 256; i++) pre[i] = mem[i];
    is_c = (op == 3'd3) || (op == 3'd5);
    tk   = !is_c || bench_cond(cnd, flg);
    s1   = sp + 16'd1;
    en = 0; epc = npc; esp = sp; epair = 16'h0;
    for (int i = 0; i < 4; i++) begin ea[i] = '0; ew[i] = 0; ed[i] = '0; end
    if (tk) begin
      case (op)
        3'd0, 3'd2, 3'd3, 3'd6: begin
          sv = (op == 3'd0) ? pair : npc;
          en = 2;
          ea[0] = sp - 16'd1; ew[0] = 1; ed[0] = sv[15:8];
          ea[1] = sp - 16'd2; ew[1] = 1; ed[1] = sv[7:0];
          esp = sp - 16'd2;
          if (op == 3'd6)      epc = 16'(vec) * 16'd8;
          else if (op != 3'd0) epc = tgt;
        end
        3'd1, 3'd4, 3'd5: begin
          en = 2;
          ea[0] = sp; ea[1] = s1;
          epair = {pre[s1[7:0]], pre[sp[7:0]]};
          esp = sp + 16'd2;
          if (op != 3'd1) epc = epair;
        end
        default: begin
          en = 4;
          ea[0] = sp; ea[1] = sp; ew[1] = 1; ed[1] = pair[7:0];
          ea[2] = s1; ea[3] = s1; ew[3] = 1; ed[3] = pair[15:8];
          epair = {pre[s1[7:0]], pre[sp[7:0]]};
        end
      endcase
    end
    for (int i = 0; i < 256; i++) post[i] = pre[i];
    for (int i = 0; i < en; i++) if (ew[i]) post[ea[i][7:0]] = ed[i];

    hold_rdy = (stall > 0);
    @(negedge clk);
    log_n = 0;
    cmd_op = op; cmd_cond = cnd; cmd_vec = vec; cmd_sp = sp; cmd_pair = pair;
    cmd_target = tgt; cmd_next_pc = npc;
    {flag_sign, flag_parity, flag_carry, flag_zero} = flg;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (tk) chk({tag, " R10 busy after accept"}, 32'(busy), 32'd1);
    else begin
      chk({tag, " R8 skip done next cycle"}, 32'(done), 32'd1);
      chk({tag, " R8 skip no busy"}, 32'(busy), 32'd0);
    end
    if (tk && stall > 0) begin
      for (int k = 0; k < stall; k++) begin
        chk({tag, " R9 request held"}, {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, ea[0]});
        @(posedge clk);
        if (k == stall - 1) hold_rdy = 1'b0;
        @(negedge clk);
      end
    end
    w = 0;
    while (!done && w < 300) begin
      if (noise && ($urandom % 2 == 0)) begin
        // R10: offered while busy, must be ignored
        cmd_op = 3'($urandom); cmd_sp = 16'($urandom); cmd_pair = 16'($urandom);
        cmd_cond = 3'($urandom); cmd_valid = 1'b1;
      end else cmd_valid = 1'b0;
      @(negedge clk);
      w++;
    end
    cmd_valid = 1'b0;
    hold_rdy = 1'b0;
    if (w >= 300) begin
      chk({tag, " R10 command never finished"}, 32'(done), 32'd1);
      return;
    end
    chk({tag, " taken"}, 32'(res_taken), 32'(tk));
    chk({tag, " result PC"}, 32'(res_pc), 32'(epc));
    chk({tag, " result SP"}, 32'(res_sp), 32'(esp));
    chk({tag, " result pair"}, 32'(res_pair), 32'(epair));
    chk({tag, " access count"}, 32'(log_n), 32'(en));
    for (int i = 0; i < en && i < log_n; i++) begin
      chk({tag, " access addr"}, 32'(log_addr[i]), 32'(ea[i]));
      chk({tag, " access dir"}, 32'(log_we[i]), 32'(ew[i]));
      if (ew[i]) chk({tag, " access data"}, 32'(log_data[i]), 32'(ed[i]));
    end
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== post[i]) mism++;
    chk({tag, " memory image"}, 32'(mism), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R10 watchdog expired got=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    // R12: reset state
    chk("R12 busy", 32'(busy), 0);
    chk("R12 done", 32'(done), 0);
    chk("R12 req", 32'(mem_req), 0);
    chk("R12 taken", 32'(res_taken), 0);
    chk("R12 outputs", {res_pc, res_sp}, 0);
    chk("R12 pair", 32'(res_pair), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R1", 3'd0, 0, 0, 16'h8000, 16'hA55A, 16'h0, 16'h1111, 4'h0, 0, 0);
    run("R2", 3'd1, 0, 0, 16'h7FFE, 16'h0, 16'h0, 16'h2222, 4'h0, 0, 0);
    run("R3", 3'd2, 0, 0, 16'h4000, 16'h0, 16'hBEEF, 16'h1234, 4'h0, 0, 0);
    run("R4", 3'd4, 0, 0, 16'h3FFE, 16'h0, 16'h0, 16'h9999, 4'h0, 0, 0);
    for (int c = 0; c < 8; c++) begin
      run("R5 cond call flags clear", 3'd3, 3'(c), 0, 16'h5000, 0, 16'hC0DE, 16'h0101, 4'h0, 0, 0);
      run("R5 cond call flags set",   3'd3, 3'(c), 0, 16'h5000, 0, 16'hC0DE, 16'h0101, 4'hF, 0, 0);
      run("R5 cond ret flags clear",  3'd5, 3'(c), 0, 16'h6000, 0, 0, 16'h0202, 4'h0, 0, 0);
      run("R5 cond ret flags set",    3'd5, 3'(c), 0, 16'h6000, 0, 0, 16'h0202, 4'hF, 0, 0);
    end
    for (int v = 0; v < 8; v++)
      run("R6", 3'd6, 0, 3'(v), 16'h2000, 0, 16'hFFFF, 16'h0ABC, 4'h0, 0, 0);
    run("R7", 3'd7, 0, 0, 16'h1000, 16'h1357, 0, 16'h0042, 4'h0, 0, 0);
    run("R11 push wrap", 3'd0, 0, 0, 16'h0000, 16'hCAFE, 0, 16'h0001, 4'h0, 0, 0);
    run("R11 pop wrap", 3'd1, 0, 0, 16'hFFFF, 0, 0, 16'h0002, 4'h0, 0, 0);
    run("R11 swap wrap", 3'd7, 0, 0, 16'hFFFF, 16'h8421, 0, 16'h0003, 4'h0, 0, 0);
    run("R11 call wrap", 3'd2, 0, 0, 16'h0001, 0, 16'h7777, 16'h0004, 4'h0, 0, 0);
    run("R9 stalled push", 3'd0, 0, 0, 16'h1234, 16'h5678, 0, 16'h0005, 4'h0, 0, 5);
    run("R9 stalled swap", 3'd7, 0, 0, 16'h4321, 16'h9ABC, 0, 16'h0006, 4'h0, 0, 3);
    run("R10 busy ignores", 3'd7, 0, 0, 16'h0880, 16'h0F0F, 0, 16'h0007, 4'h0, 1, 0);

    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'($urandom);
      run(op_tag(op), op, 3'($urandom), 3'($urandom), 16'($urandom), 16'($urandom),
          16'($urandom), 16'($urandom), 4'($urandom), bit'($urandom % 2),
          ($urandom % 8 == 0) ? 2 : 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule